// File: doc/BRIEF.md
# Host-Side Framed Byte Link Controller

This block runs the host end of a three-wire packet link to a small peripheral controller. Bytes move through an external 8-bit shift register whose bit clock comes from the peripheral. The block tells that register which way to shift, loads bytes into it and takes finished bytes from it. It drives two active-low control lines toward the peripheral: a frame-active line (`tip_n`) and a byte-accept line (`ack_n`). The byte-accept line acknowledges each byte by changing level, not by pulsing. It watches one active-low request line (`req_n`) from the peripheral. A two-flop synchronizer retimes that line before any decision uses it.

Toward the system, a packet to send is written into a small transmit buffer and launched with a length and a start strobe. `tx_busy` stays high until that packet has fully left. A packet from the peripheral ends when the peripheral drops its request, not when a length field says so. It is handed over as a type byte, a payload length, a valid pulse and a random-read payload buffer. When the peripheral asks to talk during a host write, the write is abandoned and the incoming frame is taken. After a fixed quiet gap, the host frame is sent again from its first byte. After reset, a timed pulse sequence on the two host lines resets the peripheral's link logic before the link accepts traffic.

Top module: `framed_link_host`

## Requirements
- R1: While reset is held, `tip_n` and `ack_n` are 1 and `link_ready` and `tx_busy` are 0. After release, `tip_n` falls RST_GAP cycles later. `ack_n` falls after a further RST_GAP cycles, then `tip_n` rises after another RST_GAP cycles. After one more RST_GAP cycles, `ack_n` rises and `link_ready` goes to 1. A `tx_start` given before `link_ready` is ignored.
- R2: When the controller is idle, `tip_n` and `ack_n` are 1 and `sr_dir_out` is 0.
- R3: A `tx_start` with a nonzero `tx_len`, issued while idle and with the request deasserted, makes `tx_busy` 1. Two cycles after the strobe, the block sets `sr_dir_out` to 1, pulses `sr_load` with buffer entry 0, holds `ack_n` at 1 and drives `tip_n` to 0.
- R4: During a write, each `sr_done` that sees the request deasserted, with bytes still to go, loads the next buffer entry with an `sr_load` pulse and inverts `ack_n`.
- R5: The `sr_done` for the last byte (number `tx_len`) returns `tip_n` and `ack_n` to 1, sets `sr_dir_out` to 0 and drops `tx_busy`.
- R6: An `sr_done` during a write that sees the request asserted abandons the write. On that `sr_done` the block sets `sr_dir_out` to 0, keeps `tip_n` at 0, holds `ack_n` at 1, keeps `tx_busy` at 1 and captures `sr_rx_byte` as the type of a frame now being received.
- R7: An `sr_done` while idle with the request deasserted changes no output.
- R8: An `sr_done` while idle with the request asserted captures the type byte and drives `tip_n` to 0. Each later `sr_done` stores a payload byte. If the request is still asserted, `ack_n` inverts. If the request is deasserted, that byte ends the frame: `tip_n` and `ack_n` go to 1 and `rx_valid` pulses for one cycle. With that pulse come `rx_type`, an `rx_len` equal to the frame's byte count minus one, and the payload readable at `rx_rd_addr` 0 and up.
- R9: A frame still requested when its RX_DEPTH-th byte arrives ends on that byte with `rx_overflow` = 1 and `rx_len` = RX_DEPTH-1. A frame ended by the request has `rx_overflow` = 0.
- R10: When a received frame ends with a send pending, the next host frame starts POST_GAP+1 cycles after the last byte, beginning at buffer entry 0. If the request is asserted when the gap ends, nothing starts until the request is deasserted.
- R11: A `tx_start` while `tx_busy` is 1 has no effect on the frame in flight. A `tx_start` with `tx_len` = 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Peripheral request, active low, asynchronous |
| tip_n | output | 1 | Frame-active line to peripheral, active low |
| ack_n | output | 1 | Byte-accept line to peripheral, level toggled per byte |
| sr_dir_out | output | 1 | Shift register direction, 1 = host sends |
| sr_load | output | 1 | One-cycle strobe: load `sr_tx_byte` into shift register |
| sr_tx_byte | output | 8 | Byte to shift out |
| sr_done | input | 1 | One-cycle pulse: shift register finished a byte |
| sr_rx_byte | input | 8 | Byte just shifted in |
| tx_wr_en | input | 1 | Transmit buffer write enable |
| tx_wr_addr | input | $clog2(TX_DEPTH) | Transmit buffer write address |
| tx_wr_data | input | 8 | Transmit buffer write data |
| tx_len | input | $clog2(TX_DEPTH+1) | Number of bytes to send, sampled on `tx_start` |
| tx_start | input | 1 | Request to send the buffered packet |
| tx_busy | output | 1 | A host packet is pending or in flight |
| link_ready | output | 1 | Reset pulse sequence finished |
| rx_valid | output | 1 | One-cycle pulse: received packet available |
| rx_type | output | 8 | First byte of the received frame |
| rx_len | output | $clog2(RX_DEPTH+1) | Payload byte count of the received frame |
| rx_overflow | output | 1 | Received frame was cut at buffer capacity |
| rx_rd_addr | input | $clog2(RX_DEPTH) | Payload read address |
| rx_rd_data | output | 8 | Payload byte at `rx_rd_addr` |

## Verification
The bench targets the race where the peripheral requests the link mid-write. A design that fails to back off here keeps shifting host bytes, and one that fails to rewind resends from the middle of the packet; either fault shows up in the order of the loaded bytes and in `tx_busy`. It times the quiet gap after a received frame and holds the request asserted across the end of that gap. A controller that does not recheck the request would start a write into a collision. It also drives a frame longer than the buffer, a stray shift completion while idle, and start strobes issued while busy or while the reset sequence is running. A wrong design would cut the frame at the wrong count, answer a false start, or let a second request corrupt the packet in flight.

// File: rtl/framed_link_host.sv
module framed_link_host #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 256,
  parameter int RST_GAP  = 15000,
  parameter int POST_GAP = 150000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_n,
  output logic                          tip_n,
  output logic                          ack_n,
  output logic                          sr_dir_out,
  output logic                          sr_load,
  output logic [7:0]                    sr_tx_byte,
  input  logic                          sr_done,
  input  logic [7:0]                    sr_rx_byte,
  input  logic                          tx_wr_en,
  input  logic [$clog2(TX_DEPTH)-1:0]   tx_wr_addr,
  input  logic [7:0]                    tx_wr_data,
  input  logic [$clog2(TX_DEPTH+1)-1:0] tx_len,
  input  logic                          tx_start,
  output logic                          tx_busy,
  output logic                          link_ready,
  output logic                          rx_valid,
  output logic [7:0]                    rx_type,
  output logic [$clog2(RX_DEPTH+1)-1:0] rx_len,
  output logic                          rx_overflow,
  input  logic [$clog2(RX_DEPTH)-1:0]   rx_rd_addr,
  output logic [7:0]                    rx_rd_data
);
  localparam int TAW  = $clog2(TX_DEPTH);
  localparam int TLW  = $clog2(TX_DEPTH + 1);
  localparam int RAW  = $clog2(RX_DEPTH);
  localparam int CW   = $clog2(RX_DEPTH + 1);
  localparam int GMAX = (RST_GAP > POST_GAP) ? RST_GAP : POST_GAP;
  localparam int TW   = $clog2(GMAX + 1);

  typedef enum logic [2:0] {S_RST, S_IDLE, S_TX, S_RX, S_GAP} state_t;

  state_t         state;
  logic [1:0]     req_sync;
  logic [1:0]     step;
  logic [TW-1:0]  tmr;
  logic           pending;
  logic [TLW-1:0] len_q, idx, nxt;
  logic [CW-1:0]  cnt;
  logic [RAW-1:0] wptr;
  logic [7:0]     tx_mem [TX_DEPTH];
  logic [7:0]     rx_mem [RX_DEPTH];

  wire req_on = ~req_sync[1];
  assign nxt        = idx + 1'b1;
  assign wptr       = RAW'(cnt - 1'b1);
  assign tx_busy    = pending;
  assign rx_rd_data = rx_mem[rx_rd_addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_sync <= 2'b11;
    else        req_sync <= {req_sync[0], req_n};

  always_ff @(posedge clk)
    if (tx_wr_en) tx_mem[tx_wr_addr] <= tx_wr_data;

  always_ff @(posedge clk)
    if (state == S_RX && sr_done) rx_mem[wptr] <= sr_rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RST;  step <= '0;  tmr <= '0;
      tip_n <= 1'b1;   ack_n <= 1'b1;  sr_dir_out <= 1'b0;
      sr_load <= 1'b0; sr_tx_byte <= '0;
      pending <= 1'b0; len_q <= '0;  idx <= '0;  cnt <= '0;
      rx_valid <= 1'b0; rx_type <= '0; rx_len <= '0; rx_overflow <= 1'b0;
      link_ready <= 1'b0;
    end else begin
      sr_load  <= 1'b0;
      rx_valid <= 1'b0;
      if (tx_start && !pending && link_ready && tx_len != '0) begin
        pending <= 1'b1;
        len_q   <= tx_len;
      end
      case (state)
        S_RST:
          if (tmr == TW'(RST_GAP - 1)) begin
            tmr  <= '0;
            step <= step + 1'b1;
            case (step)
              2'd0: tip_n <= 1'b0;
              2'd1: ack_n <= ~ack_n;
              2'd2: tip_n <= 1'b1;
              default: begin
                ack_n <= 1'b1;
                link_ready <= 1'b1;
                state <= S_IDLE;
              end
            endcase
          end else tmr <= tmr + 1'b1;
        S_IDLE:
          if (sr_done && req_on) begin
            rx_type <= sr_rx_byte;
            cnt     <= CW'(1);
            tip_n   <= 1'b0;
            state   <= S_RX;
          end else if (pending && !req_on) begin
            sr_dir_out <= 1'b1;
            sr_tx_byte <= tx_mem[0];
            sr_load    <= 1'b1;
            ack_n      <= 1'b1;
            tip_n      <= 1'b0;
            idx        <= '0;
            state      <= S_TX;
          end
        S_TX:
          if (sr_done) begin
            if (req_on) begin
              sr_dir_out <= 1'b0;
              ack_n      <= 1'b1;
              tip_n      <= 1'b0;
              idx        <= '0;
              rx_type    <= sr_rx_byte;
              cnt        <= CW'(1);
              state      <= S_RX;
            end else if (nxt == len_q) begin
              pending    <= 1'b0;
              sr_dir_out <= 1'b0;
              tip_n      <= 1'b1;
              ack_n      <= 1'b1;
              state      <= S_IDLE;
            end else begin
              idx        <= nxt;
              sr_tx_byte <= tx_mem[TAW'(nxt)];
              sr_load    <= 1'b1;
              ack_n      <= ~ack_n;
            end
          end
        S_RX:
          if (sr_done) begin
            cnt <= cnt + 1'b1;
            if (!req_on || cnt == CW'(RX_DEPTH - 1)) begin
              tip_n       <= 1'b1;
              ack_n       <= 1'b1;
              rx_valid    <= 1'b1;
              rx_len      <= cnt;
              rx_overflow <= req_on;
              tmr         <= '0;
              state       <= pending ? S_GAP : S_IDLE;
            end else ack_n <= ~ack_n;
          end
        S_GAP:
          if (tmr == TW'(POST_GAP - 1)) begin
            tmr   <= '0;
            state <= S_IDLE;
          end else tmr <= tmr + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_notready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ready |-> !tx_busy);
  assert_idle_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (tip_n && ack_n && !sr_dir_out));
  assert_load_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |-> (sr_dir_out && !tip_n));
  assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $rose(tip_n));
  assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_ovf_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_overflow) |-> (rx_len == CW'(RX_DEPTH - 1)));
endmodule

// File: tb/test_framed_link_host.sv
module test_framed_link_host;
  localparam int TXD = 16, RXD = 256, RG = 20, PG = 40;

  logic clk = 1'b0, rst_n = 1'b0, req_n = 1'b1;
  logic tip_n, ack_n, sr_dir_out, sr_load, tx_busy, link_ready;
  logic rx_valid, rx_overflow;
  logic [7:0] sr_tx_byte, rx_type, rx_rd_data;
  logic sr_done = 1'b0, tx_wr_en = 1'b0, tx_start = 1'b0;
  logic [7:0] sr_rx_byte = '0, tx_wr_data = '0;
  logic [3:0] tx_wr_addr = '0;
  logic [4:0] tx_len = '0;
  logic [8:0] rx_len;
  logic [7:0] rx_rd_addr = '0;

  int compared = 0, mismatched = 0, cyc = 0, t0;
  logic [7:0]  exp_tx[$];
  logic [17:0] exp_rx[$];
  logic [7:0]  etx;
  logic [17:0] erx;

  framed_link_host #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .RST_GAP(RG), .POST_GAP(PG)) i_framed_link_host (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .tip_n(tip_n), .ack_n(ack_n),
    .sr_dir_out(sr_dir_out), .sr_load(sr_load), .sr_tx_byte(sr_tx_byte),
    .sr_done(sr_done), .sr_rx_byte(sr_rx_byte), .tx_wr_en(tx_wr_en),
    .tx_wr_addr(tx_wr_addr), .tx_wr_data(tx_wr_data), .tx_len(tx_len),
    .tx_start(tx_start), .tx_busy(tx_busy), .link_ready(link_ready),
    .rx_valid(rx_valid), .rx_type(rx_type), .rx_len(rx_len),
    .rx_overflow(rx_overflow), .rx_rd_addr(rx_rd_addr), .rx_rd_data(rx_rd_data));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // monitor: scoreboard for loaded bytes and delivered packet headers
  always @(negedge clk) begin
    if (rst_n && sr_load) begin
      if (exp_tx.size() == 0) chk(1'b0, "R4 unexpected byte load", sr_tx_byte, 0);
      else begin
        etx = exp_tx.pop_front();
        chk(sr_tx_byte == etx, "R4 loaded byte", sr_tx_byte, etx);
      end
    end
    if (rst_n && rx_valid) begin
      if (exp_rx.size() == 0) chk(1'b0, "R8 unexpected packet", rx_type, 0);
      else begin
        erx = exp_rx.pop_front();
        chk({rx_type, rx_len, rx_overflow} == erx, "R8 packet header",
            {rx_type, rx_len, rx_overflow}, erx);
      end
    end
  end

  task automatic byte_in(input logic [7:0] b);
    @(negedge clk); sr_rx_byte = b; sr_done = 1'b1;
    @(negedge clk); sr_done = 1'b0;
  endtask

  task automatic set_req(input logic v);
    @(negedge clk); req_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_tx(input int a, input logic [7:0] d);
    @(negedge clk); tx_wr_en = 1'b1; tx_wr_addr = 4'(a); tx_wr_data = d;
    @(negedge clk); tx_wr_en = 1'b0;
  endtask

  task automatic start_tx(input int l);
    @(negedge clk); tx_len = 5'(l); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tip_n && ack_n && !link_ready && !tx_busy, "R1 reset state",
        {tip_n, ack_n, link_ready, tx_busy}, 4'b1100);
    rst_n = 1'b1; t0 = cyc;
    while (tip_n !== 1'b0) @(negedge clk);
    chk(cyc - t0 == RG, "R1 tip low time", cyc - t0, RG);
    start_tx(1);
    chk(!tx_busy, "R1 start ignored before ready", tx_busy, 0);
    while (ack_n !== 1'b0) @(negedge clk);
    chk(cyc - t0 == 2*RG, "R1 ack toggle time", cyc - t0, 2*RG);
    while (tip_n !== 1'b1) @(negedge clk);
    chk(cyc - t0 == 3*RG, "R1 tip release time", cyc - t0, 3*RG);
    while (ack_n !== 1'b1) @(negedge clk);
    chk(cyc - t0 == 4*RG && link_ready, "R1 final idle and ready", cyc - t0, 4*RG);
    @(negedge clk);
    chk(tip_n && ack_n && !sr_dir_out && !tx_busy, "R2 idle lines",
        {tip_n, ack_n, sr_dir_out, tx_busy}, 4'b1100);

    // R7: stray shift completion while idle
    byte_in(8'h5A);
    @(negedge clk);
    chk(tip_n && ack_n && !sr_dir_out, "R7 false start ignored",
        {tip_n, ack_n, sr_dir_out}, 3'b110);

    // R3/R4/R5/R11: three byte host frame
    wr_tx(0, 8'hA1); wr_tx(1, 8'hB2); wr_tx(2, 8'hC3);
    exp_tx.push_back(8'hA1); exp_tx.push_back(8'hB2); exp_tx.push_back(8'hC3);
    start_tx(3);
    @(negedge clk);
    chk(!tip_n && ack_n && sr_dir_out && tx_busy, "R3 frame start",
        {tip_n, ack_n, sr_dir_out, tx_busy}, 4'b0111);
    start_tx(5);   // R11: ignored while busy
    byte_in(8'h00);
    chk(!ack_n && !tip_n, "R4 ack toggles after byte 1", ack_n, 0);
    byte_in(8'h00);
    chk(ack_n && !tip_n, "R4 ack toggles after byte 2", ack_n, 1);
    byte_in(8'h00);
    chk(tip_n && ack_n && !sr_dir_out && !tx_busy, "R5 frame complete",
        {tip_n, ack_n, sr_dir_out, tx_busy}, 4'b1100);
    repeat (4) @(negedge clk);
    chk(exp_tx.size() == 0 && tip_n, "R11 no extra bytes after busy start", exp_tx.size(), 0);
    start_tx(0);
    @(negedge clk);
    chk(!tx_busy, "R11 zero length ignored", tx_busy, 0);

    // R8: peripheral frame of four bytes
    exp_rx.push_back({8'h05, 9'd3, 1'b0});
    set_req(1'b0);
    byte_in(8'h05);
    chk(!tip_n && ack_n && !sr_dir_out, "R8 receive start", {tip_n, ack_n}, 2'b01);
    byte_in(8'h11);
    chk(!ack_n, "R8 ack toggles", ack_n, 0);
    byte_in(8'h22);
    chk(ack_n, "R8 ack toggles back", ack_n, 1);
    set_req(1'b1);
    byte_in(8'h33);
    chk(tip_n && ack_n, "R8 frame end lines idle", {tip_n, ack_n}, 2'b11);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rx_rd_addr = 8'(k); #1;
      chk(rx_rd_data == 8'(8'h11 * (k + 1)), "R8 payload byte", rx_rd_data, 8'h11 * (k + 1));
    end

    // R6/R10: collision during write, retry after gap
    wr_tx(0, 8'h10); wr_tx(1, 8'h20);
    exp_tx.push_back(8'h10); exp_tx.push_back(8'h20);
    exp_tx.push_back(8'h10); exp_tx.push_back(8'h20);
    exp_rx.push_back({8'h07, 9'd2, 1'b0});
    start_tx(2);
    @(negedge clk);
    byte_in(8'h00);
    set_req(1'b0);
    byte_in(8'h07);
    chk(!tip_n && ack_n && !sr_dir_out && tx_busy, "R6 abort to receive",
        {tip_n, ack_n, sr_dir_out, tx_busy}, 4'b0101);
    byte_in(8'h44);
    set_req(1'b1);
    byte_in(8'h55);
    t0 = cyc;
    chk(tx_busy && tip_n, "R6 send kept pending", tx_busy, 1);
    while (sr_load !== 1'b1) @(negedge clk);
    chk(cyc - t0 == PG + 1, "R10 retry after gap", cyc - t0, PG + 1);
    byte_in(8'h00);
    byte_in(8'h00);
    chk(!tx_busy && exp_tx.size() == 0, "R6 retry from first byte done", exp_tx.size(), 0);

    // R10: request asserted at end of gap holds off the send
    wr_tx(0, 8'h77);
    exp_rx.push_back({8'h09, 9'd2, 1'b0});
    set_req(1'b0);
    byte_in(8'h09);
    start_tx(1);
    chk(tx_busy && !sr_dir_out, "R11 start held during receive", tx_busy, 1);
    byte_in(8'h66);
    set_req(1'b1);
    byte_in(8'h01);
    @(negedge clk); req_n = 1'b0;
    repeat (PG + 10) @(negedge clk);
    chk(tip_n && tx_busy, "R10 back-off while request asserted", {tip_n, tx_busy}, 2'b11);
    exp_tx.push_back(8'h77);
    @(negedge clk); req_n = 1'b1;
    while (sr_load !== 1'b1) @(negedge clk);
    chk(!tip_n, "R10 starts once request clears", tip_n, 0);
    byte_in(8'h00);
    chk(!tx_busy && tip_n, "R10 held frame completes", tx_busy, 0);

    // R9: overflow
    exp_rx.push_back({8'h00, 9'(RXD - 1), 1'b1});
    set_req(1'b0);
    for (int k = 0; k < RXD - 1; k++) byte_in(8'(k));
    chk(!tip_n, "R9 frame open before capacity", tip_n, 0);
    byte_in(8'hFF);
    chk(tip_n && ack_n, "R9 frame cut at capacity", {tip_n, ack_n}, 2'b11);
    @(negedge clk); rx_rd_addr = 8'd254; #1;
    chk(rx_rd_data == 8'hFF, "R9 last payload byte", rx_rd_data, 8'hFF);
    set_req(1'b1);
    repeat (4) @(negedge clk);
    chk(exp_rx.size() == 0 && exp_tx.size() == 0, "R8 scoreboard drained",
        exp_rx.size() + exp_tx.size(), 0);
    summary();
    $finish;
  end
endmodule